// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one channel of a periodic timer. A 32-bit counter counts down on prescaled ticks of a peripheral clock enable. A tick that finds the counter at zero while the channel is started is an underflow. On an underflow the counter reloads from a 32-bit reload constant and a sticky underflow flag is set. The channel drives a level interrupt while that flag and its enable bit are both set.

Software reaches the channel through a plain register port: a write strobe, a 2-bit word index, write data, and a combinational read-data output for the indexed word. Word 0 is the reload constant, word 1 is the live counter, word 2 is control and status, and word 3 is a general capture register. The word index is meant to come from byte address bits [3:2]. A separate start input gates counting. A peripheral clock enable input feeds a free-running prescaler. A 3-bit code in the control word picks that prescaler's divide ratio, in steps of four.

Top module: `tmr_reload_chan`

## Requirements
- R1: After reset the reload constant and the counter both read 0xFFFFFFFF, control reads 0, and `irq_o` is low.
- R2: Word index 0 writes and reads the reload constant, and word index 1 writes and reads the counter. A counter write replaces the current value.
- R3: With `pclk_en_i` held high, control bits [2:0] set to code k (0 to 4) make the counter decrement every 4^(k+1) cycles. The first decrement comes 4^(k+1) clock edges after the edge that writes control.
- R4: Control codes 5, 6 and 7 produce no ticks, so the counter holds its value.
- R5: A tick that finds the counter at 0 while `run_i` is high loads the reload constant into the counter and sets the underflow flag. The flag reads back in control bit 8.
- R6: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged.
- R7: `irq_o` is high exactly when the flag is set and control bit 5 (interrupt enable) is 1. The flag still sets while the enable bit is 0.
- R8: Control keeps written bits [7:0]. Bits [31:9] of a write are ignored and read back as 0.
- R9: A control write restarts the prescaler from zero and leaves the counter value unchanged.
- R10: While `run_i` is low the counter does not change except by a register write.
- R11: When `HAS_CAPTURE` is 1, word 3 is a read/write register. When it is 0, word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel start; counting only while high |
| pclk_en_i | input | 1 | Peripheral clock enable feeding the prescaler |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data of the indexed word (combinational) |
| irq_o | output | 1 | Level interrupt: flag AND enable |

## Verification
A register write lands on the clock edge that samples it. A read is combinational, so the bench checks it half a cycle after it drives the index. The counter has one register after the prescaler tick. With code k, the first decrement therefore lands 4^(k+1) edges after the control-write edge. The bench reads the counter one edge before that point and again on that edge, so a tick that comes one cycle early or late is caught. The flag and `irq_o` follow the underflow edge directly, and the bench samples them on the falling edge after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int CODE_W   = 3;
    localparam int CTL_W    = 8;
    localparam int NUM_DIV  = 5;
    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;

    localparam logic [ADDR_W-1:0] IDX_RELOAD = 2'd0;
    localparam logic [ADDR_W-1:0] IDX_COUNT  = 2'd1;
    localparam logic [ADDR_W-1:0] IDX_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] IDX_CAPT   = 2'd3;

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] cnt;
        logic [CTL_W-1:0]  ctl;
        logic              flag;
        logic [DATA_W-1:0] capt;
    } chan_state_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int N_DIV = NUM_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int PS_W = 2 * N_DIV;

    logic [PS_W-1:0]  ps_d, ps_q;
    logic [N_DIV-1:0] tap;
    logic             sel;

    // one tap per divide ratio: all low 2(k+1) bits at one
    for (genvar k = 0; k < N_DIV; k++) begin : g_tap
        assign tap[k] = &ps_q[2*k+1:0];
    end

    always_comb begin
        ps_d = ps_q;
        if (restart_i)      ps_d = '0;
        else if (pclk_en_i) ps_d = ps_q + 1'b1;
        sel = 1'b0;
        for (int k = 0; k < N_DIV; k++) begin
            if (code_i == CODE_W'(k)) sel = tap[k];
        end
        tick_o = pclk_en_i && !restart_i && sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    // R4: codes beyond the divide table never tick
    a_r4_no_tick_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i >= CODE_W'(N_DIV)) |-> !tick_o);
    // R3: ticks are never back to back (divide of at least four)
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_pkg::*;
#(
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CODE_W-1:0] code_o,
    output logic              ctl_wr_o,
    output logic              irq_o
);
    chan_state_t st_d, st_q;
    logic cnt_wr, underflow;

    always_comb begin
        st_d      = st_q;
        cnt_wr    = wr_i && (addr_i == IDX_COUNT);
        ctl_wr_o  = wr_i && (addr_i == IDX_CTRL);
        underflow = tick_i && run_i && (st_q.cnt == '0);

        if (wr_i && addr_i == IDX_RELOAD) st_d.reload = wdata_i;

        if (cnt_wr)                 st_d.cnt = wdata_i;
        else if (underflow)         st_d.cnt = st_q.reload;
        else if (tick_i && run_i)   st_d.cnt = st_q.cnt - 1'b1;

        if (ctl_wr_o) st_d.ctl = wdata_i[CTL_W-1:0];

        // a new underflow wins over a clear in the same cycle
        if (underflow)                            st_d.flag = 1'b1;
        else if (ctl_wr_o && !wdata_i[FLAG_BIT])  st_d.flag = 1'b0;

        if (HAS_CAPTURE && wr_i && addr_i == IDX_CAPT) st_d.capt = wdata_i;

        unique case (addr_i)
            IDX_RELOAD: rdata_o = st_q.reload;
            IDX_COUNT:  rdata_o = st_q.cnt;
            IDX_CTRL:   rdata_o = DATA_W'({st_q.flag, st_q.ctl});
            default:    rdata_o = HAS_CAPTURE ? st_q.capt : '0;
        endcase

        code_o = st_q.ctl[CODE_W-1:0];
        irq_o  = st_q.flag && st_q.ctl[IE_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.reload <= '1;
            st_q.cnt    <= '1;
            st_q.ctl    <= '0;
            st_q.flag   <= 1'b0;
            st_q.capt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: underflow loads the reload constant
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && st_q.cnt == '0 && !cnt_wr) |=> (st_q.cnt == $past(st_q.reload)));
    // R5: the flag only rises after an underflow
    a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(tick_i && run_i && st_q.cnt == '0));
    // R6: only a zero written to the flag bit clears it
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(ctl_wr_o && !wdata_i[FLAG_BIT])) |=> st_q.flag);
    // R10: a stopped channel holds its count
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_wr) |=> $stable(st_q.cnt));
endmodule

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
    import tmr_pkg::*;
#(
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              pclk_en_i,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    logic              tick, ctl_wr;
    logic [CODE_W-1:0] code;

    tmr_prescale #(.N_DIV(NUM_DIV)) u_ps (
        .clk       (clk),
        .rst_n     (rst_n),
        .pclk_en_i (pclk_en_i),
        .restart_i (ctl_wr),
        .code_i    (code),
        .tick_o    (tick)
    );

    tmr_chan_regs #(.HAS_CAPTURE(HAS_CAPTURE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .tick_i   (tick),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .code_o   (code),
        .ctl_wr_o (ctl_wr),
        .irq_o    (irq_o)
    );
endmodule

// File: tb/sim_tmr_reload_chan.sv
module sim_tmr_reload_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        pclk_en_i = 1'b1;
    logic        wr_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o, rdata1;
    logic        irq_o, irq1;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tmr_reload_chan #(.HAS_CAPTURE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .pclk_en_i(pclk_en_i),
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o));
    tmr_reload_chan #(.HAS_CAPTURE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .pclk_en_i(pclk_en_i),
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata1), .irq_o(irq1));

    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_WAIT = 3'd2,
                           K_RUN = 3'd3, K_IRQ = 3'd4, K_RD1 = 3'd5;
    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  idx;
        logic [31:0] val;
        logic [7:0]  req;
    } vec_t;
    localparam int N_VEC = 49;
    // val: write data, wait count, run level, or expected value
    localparam vec_t VEC [N_VEC] = '{
        '{K_WR,   2'd0, 32'h2,        8'd2},
        '{K_WR,   2'd1, 32'h1,        8'd2},
        '{K_RD,   2'd0, 32'h2,        8'd2},   // R2
        '{K_RD,   2'd1, 32'h1,        8'd10},  // R10 stopped
        '{K_RUN,  2'd0, 32'h1,        8'd0},
        '{K_WR,   2'd2, 32'h20,       8'd3},
        '{K_RD,   2'd1, 32'h1,        8'd9},   // R9 count kept
        '{K_WAIT, 2'd0, 32'd3,        8'd0},
        '{K_RD,   2'd1, 32'h1,        8'd3},   // R3 not yet
        '{K_WAIT, 2'd0, 32'd1,        8'd0},
        '{K_RD,   2'd1, 32'h0,        8'd3},   // R3 divide 4
        '{K_RD,   2'd2, 32'h20,       8'd8},
        '{K_IRQ,  2'd0, 32'h0,        8'd7},
        '{K_WAIT, 2'd0, 32'd4,        8'd0},
        '{K_RD,   2'd1, 32'h2,        8'd5},   // R5 reload
        '{K_RD,   2'd2, 32'h120,      8'd5},   // R5 flag
        '{K_IRQ,  2'd0, 32'h1,        8'd7},
        '{K_WR,   2'd2, 32'h120,      8'd6},
        '{K_RD,   2'd2, 32'h120,      8'd6},   // R6 keep
        '{K_WR,   2'd2, 32'h20,       8'd6},
        '{K_RD,   2'd2, 32'h20,       8'd6},   // R6 clear
        '{K_IRQ,  2'd0, 32'h0,        8'd7},
        '{K_WR,   2'd2, 32'h21,       8'd3},
        '{K_WAIT, 2'd0, 32'd15,       8'd0},
        '{K_RD,   2'd1, 32'h2,        8'd3},
        '{K_WAIT, 2'd0, 32'd1,        8'd0},
        '{K_RD,   2'd1, 32'h1,        8'd3},   // R3 divide 16
        '{K_WR,   2'd2, 32'h25,       8'd4},
        '{K_WAIT, 2'd0, 32'd100,      8'd0},
        '{K_RD,   2'd1, 32'h1,        8'd4},   // R4 code 5 stops
        '{K_WR,   2'd1, 32'h0,        8'd2},
        '{K_WR,   2'd2, 32'h0,        8'd7},
        '{K_WAIT, 2'd0, 32'd3,        8'd0},
        '{K_RD,   2'd1, 32'h0,        8'd3},
        '{K_WAIT, 2'd0, 32'd1,        8'd0},
        '{K_RD,   2'd1, 32'h2,        8'd5},
        '{K_RD,   2'd2, 32'h100,      8'd7},   // R7 flag without enable
        '{K_IRQ,  2'd0, 32'h0,        8'd7},
        '{K_WR,   2'd2, 32'h125,      8'd7},
        '{K_IRQ,  2'd0, 32'h1,        8'd7},
        '{K_WR,   2'd2, 32'hFFFF_FE25, 8'd8},
        '{K_RD,   2'd2, 32'h25,       8'd8},   // R8 upper bits dropped
        '{K_IRQ,  2'd0, 32'h0,        8'd6},
        '{K_RUN,  2'd0, 32'h0,        8'd0},
        '{K_WR,   2'd2, 32'h20,       8'd10},
        '{K_WAIT, 2'd0, 32'd12,       8'd0},
        '{K_RD,   2'd1, 32'h2,        8'd10},  // R10 hold
        '{K_WR,   2'd3, 32'h1234_ABCD, 8'd11},
        '{K_RD,   2'd3, 32'h1234_ABCD, 8'd11}  // R11
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        wr_i = 1'b1; addr_i = idx; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [31:0] exp, input string tag);
        addr_i = idx; #1;
        check(rdata_o, exp, tag);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                // R1 reset state
                rd(2'd0, 32'hFFFF_FFFF, "R1 reload");
                rd(2'd1, 32'hFFFF_FFFF, "R1 count");
                rd(2'd2, 32'h0, "R1 control");
                check({31'd0, irq_o}, 32'h0, "R1 irq");
                for (int i = 0; i < N_VEC; i++) begin
                    string tag;
                    tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
                    case (VEC[i].kind)
                        K_WR:   wr(VEC[i].idx, VEC[i].val);
                        K_RD:   rd(VEC[i].idx, VEC[i].val, tag);
                        K_WAIT: repeat (VEC[i].val) @(negedge clk);
                        K_RUN:  run_i = VEC[i].val[0];
                        K_IRQ:  check({31'd0, irq_o}, VEC[i].val, tag);
                        default: begin addr_i = VEC[i].idx; #1; check(rdata1, VEC[i].val, tag); end
                    endcase
                end
                // R11: without the capture feature word 3 reads 0
                addr_i = 2'd3; #1;
                check(rdata1, 32'h0, "R11 no capture");
                // directed: R1 reset again after activity
                rst_n = 1'b0; run_i = 1'b0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                rd(2'd1, 32'hFFFF_FFFF, "R1 count after reset");
                rd(2'd2, 32'h0, "R1 control after reset");
                rd(2'd3, 32'h0, "R1 capture after reset");
                // directed: R3 largest divide (code 4, 1024)
                wr(2'd1, 32'h3);
                run_i = 1'b1;
                wr(2'd2, 32'h4);
                repeat (1023) @(negedge clk);
                rd(2'd1, 32'h3, "R3 divide 1024 early");
                @(negedge clk);
                rd(2'd1, 32'h2, "R3 divide 1024");
            end
            begin
                repeat (20000) @(negedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule